// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block sits between a byte-wide synchronous host bus and the pins of a standard parallel port that can also run EPP transfers. The host reaches five registers through an eight-byte window. Only the low three address bits are decoded. The block keeps the outgoing data byte, the control byte and the two EPP transfer bytes. It drives the data lines, the data direction and four control lines. It samples the status lines when the host reads status.

An acknowledge event from the cable side raises an interrupt request, but only when the interrupt enable in the control byte is set. A status read drops the request again. An EPP access does not drive the cable itself. It issues a one-cycle start pulse, tagged address or data and read or write, to separate cable-side logic. On an EPP read the block stays busy until that logic returns a done pulse with the captured byte. While it is busy, every other host access is ignored.

Read data is registered. It comes back with `hb_rvalid` one cycle after the read is accepted, or one cycle after the done pulse for an EPP read.

Top module: `ppt_host_regs`

## Requirements
- R1: After reset, `pd_out` is 0x00, `pd_dir_rev` is 0 (forward), `ctl_lines` is 0, `irq` and `hb_busy` are 0, and a control read returns 0xC0.
- R2: Only `hb_addr[2:0]` selects a register: offset 0 is data, 1 is status, 2 is control, 3 is EPP address and 4 is EPP data. Upper address bits have no effect.
- R3: `hb_size` 0 marks a single-byte access. A write with any other size is ignored. A read with any other size returns 0xFF with `hb_unused` set.
- R4: Writes to offsets 5–7 change nothing. Byte reads from them return 0xFF with `hb_unused` clear.
- R5: A control write stores bits 4..0. Bits 7 and 6 always read back as 1, and bit 5 always reads back as 0. `ctl_lines` follows stored bits 3..0 (bit 3 select, bit 2 init, bit 1 auto-feed, bit 0 strobe).
- R6: Bit 5 of a control write sets `pd_dir_rev` (1 = reverse/input). The direction changes only on a byte control write.
- R7: In forward mode, a data write drives `pd_out`, and a data read returns the last byte written.
- R8: In reverse mode, a data read samples `pd_in`, returns it and latches it as the data byte. The latched byte remains on `pd_out` and in later forward reads.
- R9: A status read returns {`stat_lines[4:0]`, `irq`, 0, `epp_tmo`} in bits 7..0 and clears `irq` in the next cycle.
- R10: `ack_evt` sets `irq` only while control bit 4 is set, and is otherwise ignored. If a set and a status-read clear fall in the same cycle, the set wins.
- R11: A byte write to offset 3 or 4 gives a one-cycle `epp_start` in the next cycle, with `epp_write` 1, `epp_addr` 1 for offset 3 and 0 for offset 4, and `epp_wdata` equal to the byte.
- R12: A byte read of offset 3 or 4 gives a one-cycle `epp_start` with `epp_write` 0 and sets `hb_busy`. The `epp_rdata` present with `epp_done` is returned with `hb_rvalid` in the next cycle, and `hb_busy` then falls.
- R13: Host reads and writes presented while `hb_busy` is high are ignored.
- R14: Apart from an EPP read, every accepted read returns `hb_rvalid` exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | HA_W | Host address, low 3 bits decoded |
| hb_size | input | 2 | Access size, 0 = one byte |
| hb_wr | input | 1 | Write strobe |
| hb_rd | input | 1 | Read strobe |
| hb_wdata | input | 8 | Write data |
| hb_rdata | output | 8 | Read data |
| hb_rvalid | output | 1 | Read data valid |
| hb_unused | output | 1 | Read was not a byte access |
| hb_busy | output | 1 | EPP read outstanding |
| pd_out | output | 8 | Data lines driven to the port |
| pd_in | input | 8 | Data lines sampled in reverse mode |
| pd_dir_rev | output | 1 | Data direction, 1 = reverse |
| ctl_lines | output | 4 | Select, init, auto-feed, strobe |
| stat_lines | input | 5 | Busy, ack, paper-out, select, error |
| epp_tmo | input | 1 | EPP timeout flag |
| ack_evt | input | 1 | Acknowledge event pulse |
| irq | output | 1 | Interrupt request |
| epp_start | output | 1 | EPP cycle start pulse |
| epp_addr | output | 1 | 1 = address cycle, 0 = data cycle |
| epp_write | output | 1 | 1 = write cycle |
| epp_wdata | output | 8 | EPP write byte |
| epp_done | input | 1 | EPP read completion pulse |
| epp_rdata | input | 8 | EPP read byte, valid with done |

## Verification
The assertions check, on every cycle, these cycle relations:
- the read-to-valid latency and the fixed control readback bits;
- that the direction moves only after a control write;
- that `irq` rises only after an acknowledge and falls after a status read;
- the shape of the EPP start pulse, and that busy follows an EPP read.

Only the bench scenarios show these behaviours:
- the data values: reverse-mode latching and its persistence into forward mode;
- the ignored wide, reserved and busy-time accesses, observed on the pins and in later readbacks;
- the set-beats-clear collision on the interrupt;
- the byte returned at the end of an EPP read.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned OFS_W   = 3;
  localparam int unsigned NREG    = 5;
  localparam int unsigned STAT_W  = 5;
  localparam int unsigned LINE_W  = 4;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [OFS_W-1:0] OFS_EADR = 3'd3;
  localparam logic [OFS_W-1:0] OFS_EDAT = 3'd4;

  localparam int unsigned CTL_DIR_BIT  = 5;
  localparam int unsigned CTL_IEN_BIT  = 4;
  localparam logic [DW-1:0] CTL_FIXED  = 8'hC0;
  localparam logic [DW-1:0] RD_FILL    = 8'hFF;

  typedef enum logic [0:0] {EPP_IDLE = 1'b0, EPP_WAIT = 1'b1} epp_state_e;
endpackage

// File: rtl/ppt_host_decode.sv
module ppt_host_decode
  import ppt_pkg::*;
#(
  parameter int unsigned HA_W = 16
) (
  input  logic [HA_W-1:0] hb_addr,
  input  logic [1:0]      hb_size,
  input  logic            hb_wr,
  input  logic            hb_rd,
  input  logic            hold,
  output logic [NREG-1:0] wr_hit,
  output logic [NREG-1:0] rd_hit,
  output logic            rd_wide,
  output logic            rd_void
);
  logic [OFS_W-1:0] ofs;
  logic             byte_ok;
  logic             acc_wr;
  logic             acc_rd;

  assign ofs     = hb_addr[OFS_W-1:0];
  assign byte_ok = (hb_size == 2'd0);
  assign acc_wr  = hb_wr & byte_ok & ~hold;
  assign acc_rd  = hb_rd & ~hold;
  assign rd_wide = acc_rd & ~byte_ok;
  assign rd_void = acc_rd & byte_ok & (ofs >= OFS_W'(NREG));

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = acc_wr & (ofs == OFS_W'(i));
    assign rd_hit[i] = acc_rd & byte_ok & (ofs == OFS_W'(i));
  end
endmodule

// File: rtl/ppt_ctl_regs.sv
module ppt_ctl_regs
  import ppt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] ctrl_q,
  output logic          dir_rev_q
);
  logic [DW-1:0] data_d;
  logic [DW-1:0] ctrl_d;
  logic          dir_d;
  logic          data_en;
  logic          ctrl_en;

  assign data_en = data_wr | (data_rd & dir_rev_q);
  assign ctrl_en = ctrl_wr;

  always_comb begin
    data_d = data_wr ? wdata : pd_in;
    ctrl_d = CTL_FIXED | {3'b000, wdata[CTL_IEN_BIT:0]};
    dir_d  = wdata[CTL_DIR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTL_FIXED;
      dir_rev_q <= 1'b0;
    end else if (ctrl_en) begin
      ctrl_q    <= ctrl_d;
      dir_rev_q <= dir_d;
    end
  end
endmodule

// File: rtl/ppt_irq_ctl.sv
module ppt_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_evt,
  input  logic irq_en,
  input  logic stat_rd,
  output logic irq_q
);
  logic irq_d;
  logic irq_ce;
  logic set_req;

  assign set_req = ack_evt & irq_en;
  assign irq_ce  = set_req | stat_rd;

  always_comb begin
    irq_d = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_ce) begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/ppt_epp_seq.sv
module ppt_epp_seq
  import ppt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adr_wr,
  input  logic          dat_wr,
  input  logic          adr_rd,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic          epp_done,
  input  logic [DW-1:0] epp_rdata,
  output logic          epp_start,
  output logic          epp_addr,
  output logic          epp_write,
  output logic [DW-1:0] epp_wdata,
  output logic          busy,
  output logic          ret_pulse
);
  epp_state_e    st_q, st_d;
  logic          start_d, addr_d, write_d;
  logic          kick;
  logic          kick_wr;
  logic [DW-1:0] eadr_q, edat_q;
  logic          adr_cap, dat_cap;

  assign kick    = adr_wr | dat_wr | adr_rd | dat_rd;
  assign kick_wr = adr_wr | dat_wr;
  assign busy    = (st_q == EPP_WAIT);
  assign ret_pulse = busy & epp_done;
  assign adr_cap = adr_wr | (ret_pulse & epp_addr);
  assign dat_cap = dat_wr | (ret_pulse & ~epp_addr);

  always_comb begin
    st_d    = st_q;
    start_d = kick;
    addr_d  = adr_wr | adr_rd;
    write_d = kick_wr;
    case (st_q)
      EPP_IDLE: if (adr_rd | dat_rd) st_d = EPP_WAIT;
      EPP_WAIT: if (epp_done)        st_d = EPP_IDLE;
      default:                       st_d = EPP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= EPP_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) epp_start <= 1'b0;
    else        epp_start <= start_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epp_addr  <= 1'b0;
      epp_write <= 1'b0;
    end else if (kick) begin
      epp_addr  <= addr_d;
      epp_write <= write_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eadr_q <= '0;
    else if (adr_cap) eadr_q <= adr_wr ? wdata : epp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       edat_q <= '0;
    else if (dat_cap) edat_q <= dat_wr ? wdata : epp_rdata;
  end

  assign epp_wdata = epp_addr ? eadr_q : edat_q;
endmodule

// File: rtl/ppt_host_regs.sv
module ppt_host_regs
  import ppt_pkg::*;
#(
  parameter int unsigned HA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HA_W-1:0]   hb_addr,
  input  logic [1:0]        hb_size,
  input  logic              hb_wr,
  input  logic              hb_rd,
  input  logic [7:0]        hb_wdata,
  output logic [7:0]        hb_rdata,
  output logic              hb_rvalid,
  output logic              hb_unused,
  output logic              hb_busy,
  output logic [7:0]        pd_out,
  input  logic [7:0]        pd_in,
  output logic              pd_dir_rev,
  output logic [3:0]        ctl_lines,
  input  logic [4:0]        stat_lines,
  input  logic              epp_tmo,
  input  logic              ack_evt,
  output logic              irq,
  output logic              epp_start,
  output logic              epp_addr,
  output logic              epp_write,
  output logic [7:0]        epp_wdata,
  input  logic              epp_done,
  input  logic [7:0]        epp_rdata
);
  logic [NREG-1:0] wr_hit, rd_hit;
  logic            rd_wide, rd_void;
  logic [DW-1:0]   data_q, ctrl_q;
  logic            dir_rev_q;
  logic            irq_q;
  logic            busy;
  logic            ret_pulse;
  logic [DW-1:0]   rdata_d;
  logic            rvalid_d, unused_d;
  logic            imm_rd;

  ppt_host_decode #(.HA_W(HA_W)) u_dec (
    .hb_addr (hb_addr),
    .hb_size (hb_size),
    .hb_wr   (hb_wr),
    .hb_rd   (hb_rd),
    .hold    (busy),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .rd_wide (rd_wide),
    .rd_void (rd_void)
  );

  ppt_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (wr_hit[OFS_DATA]),
    .data_rd   (rd_hit[OFS_DATA]),
    .ctrl_wr   (wr_hit[OFS_CTRL]),
    .wdata     (hb_wdata),
    .pd_in     (pd_in),
    .data_q    (data_q),
    .ctrl_q    (ctrl_q),
    .dir_rev_q (dir_rev_q)
  );

  ppt_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_evt (ack_evt),
    .irq_en  (ctrl_q[CTL_IEN_BIT]),
    .stat_rd (rd_hit[OFS_STAT]),
    .irq_q   (irq_q)
  );

  ppt_epp_seq u_epp (
    .clk       (clk),
    .rst_n     (rst_n),
    .adr_wr    (wr_hit[OFS_EADR]),
    .dat_wr    (wr_hit[OFS_EDAT]),
    .adr_rd    (rd_hit[OFS_EADR]),
    .dat_rd    (rd_hit[OFS_EDAT]),
    .wdata     (hb_wdata),
    .epp_done  (epp_done),
    .epp_rdata (epp_rdata),
    .epp_start (epp_start),
    .epp_addr  (epp_addr),
    .epp_write (epp_write),
    .epp_wdata (epp_wdata),
    .busy      (busy),
    .ret_pulse (ret_pulse)
  );

  assign imm_rd = rd_hit[OFS_DATA] | rd_hit[OFS_STAT] | rd_hit[OFS_CTRL] | rd_wide | rd_void;

  always_comb begin
    rdata_d  = RD_FILL;
    unused_d = rd_wide;
    rvalid_d = imm_rd | ret_pulse;
    if (ret_pulse)                   rdata_d = epp_rdata;
    else if (rd_hit[OFS_DATA])       rdata_d = dir_rev_q ? pd_in : data_q;
    else if (rd_hit[OFS_STAT])       rdata_d = {stat_lines, irq_q, 1'b0, epp_tmo};
    else if (rd_hit[OFS_CTRL])       rdata_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_rvalid <= 1'b0;
    end else begin
      hb_rvalid <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_rdata  <= '0;
      hb_unused <= 1'b0;
    end else if (rvalid_d) begin
      hb_rdata  <= rdata_d;
      hb_unused <= unused_d;
    end
  end

  assign hb_busy    = busy;
  assign pd_out     = data_q;
  assign pd_dir_rev = dir_rev_q;
  assign ctl_lines  = ctrl_q[LINE_W-1:0];
  assign irq        = irq_q;
endmodule

// File: rtl/ppt_host_regs_chk.sv
module ppt_host_regs_chk #(
  parameter int unsigned HA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HA_W-1:0] hb_addr,
  input logic [1:0]      hb_size,
  input logic            hb_wr,
  input logic            hb_rd,
  input logic [7:0]      hb_rdata,
  input logic            hb_rvalid,
  input logic            hb_busy,
  input logic            pd_dir_rev,
  input logic            ack_evt,
  input logic            irq,
  input logic            epp_start,
  input logic            epp_addr,
  input logic            epp_write
);
  logic byte_acc;
  logic [2:0] ofs;
  assign byte_acc = (hb_size == 2'd0) && !hb_busy;
  assign ofs      = hb_addr[2:0];

  // R14
  imm_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_rd && !hb_busy && !(hb_size == 2'd0 && (ofs == 3'd3 || ofs == 3'd4))) |=> hb_rvalid);

  // R5
  ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hb_rd && byte_acc && ofs == 3'd2) |-> (hb_rdata[7:5] == 3'b110));

  // R6
  dir_only_on_ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_dir_rev) |-> $past(hb_wr && byte_acc && ofs == 3'd2));

  // R9
  irq_clear_on_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_rd && byte_acc && ofs == 3'd1 && !ack_evt) |=> !irq);

  // R10
  irq_rise_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_evt));

  // R11
  epp_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_wr && byte_acc && ofs == 3'd3) |=> (epp_start && epp_addr && epp_write));

  // R12
  epp_rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_rd && byte_acc && ofs == 3'd4) |=> (epp_start && !epp_write && !epp_addr && hb_busy));
endmodule

bind ppt_host_regs ppt_host_regs_chk #(.HA_W(HA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hb_addr    (hb_addr),
  .hb_size    (hb_size),
  .hb_wr      (hb_wr),
  .hb_rd      (hb_rd),
  .hb_rdata   (hb_rdata),
  .hb_rvalid  (hb_rvalid),
  .hb_busy    (hb_busy),
  .pd_dir_rev (pd_dir_rev),
  .ack_evt    (ack_evt),
  .irq        (irq),
  .epp_start  (epp_start),
  .epp_addr   (epp_addr),
  .epp_write  (epp_write)
);

// File: tb/ppt_host_regs_tb.sv
module ppt_host_regs_tb;
  localparam int unsigned HA_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [HA_W-1:0] hb_addr = '0;
  logic [1:0]      hb_size = '0;
  logic            hb_wr = 1'b0, hb_rd = 1'b0;
  logic [7:0]      hb_wdata = '0;
  logic [7:0]      hb_rdata;
  logic            hb_rvalid, hb_unused, hb_busy;
  logic [7:0]      pd_out;
  logic [7:0]      pd_in = '0;
  logic            pd_dir_rev;
  logic [3:0]      ctl_lines;
  logic [4:0]      stat_lines = '0;
  logic            epp_tmo = 1'b0, ack_evt = 1'b0;
  logic            irq, epp_start, epp_addr, epp_write;
  logic [7:0]      epp_wdata;
  logic            epp_done = 1'b0;
  logic [7:0]      epp_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  ppt_host_regs #(.HA_W(HA_W)) u_dut (.*);

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (rst_n && hb_rvalid) begin
      if (exp_q.size() == 0) begin
        chk({hb_unused, hb_rdata}, 9'h1FF, "R14 unexpected rvalid");
      end else begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({hb_unused, hb_rdata}, e, t);
      end
    end
  end

  task automatic hwrite(input logic [HA_W-1:0] a, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    hb_addr = a; hb_size = s; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic hread(input logic [HA_W-1:0] a, input logic [1:0] s,
                       input logic [7:0] e, input logic u, input string tag);
    exp_q.push_back({u, e});
    tag_q.push_back(tag);
    @(negedge clk);
    hb_addr = a; hb_size = s; hb_rd = 1'b1;
    @(negedge clk);
    hb_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({1'b0, pd_out}, 9'h000, "R1 pd_out");
    chk({8'h0, pd_dir_rev}, 9'h0, "R1 dir");
    chk({5'h0, ctl_lines}, 9'h0, "R1 ctl_lines");
    chk({7'h0, irq, hb_busy}, 9'h0, "R1 irq/busy");
    hread(16'h0002, 2'd0, 8'hC0, 1'b0, "R1 ctrl reset read");

    // R7 / R2 data forward with upper address bits set
    hwrite(16'h0378, 2'd0, 8'hA5);
    chk({1'b0, pd_out}, 9'h0A5, "R7 pd_out after write");
    hread(16'hFFF8, 2'd0, 8'hA5, 1'b0, "R2 data read high addr bits");

    // R5 / R6 control write
    hwrite(16'h037A, 2'd0, 8'h3F);
    chk({8'h0, pd_dir_rev}, 9'h1, "R6 reverse dir");
    chk({5'h0, ctl_lines}, 9'h00F, "R5 ctl_lines");
    hread(16'h0002, 2'd0, 8'hDF, 1'b0, "R5 ctrl readback");

    // R8 reverse read latches pd_in
    pd_in = 8'h5C;
    hread(16'h0000, 2'd0, 8'h5C, 1'b0, "R8 reverse read");
    pd_in = 8'h11;
    hwrite(16'h0002, 2'd0, 8'h00);
    chk({8'h0, pd_dir_rev}, 9'h0, "R6 forward dir");
    chk({1'b0, pd_out}, 9'h05C, "R8 latched pd_out");
    hread(16'h0000, 2'd0, 8'h5C, 1'b0, "R8 forward read after reverse");

    // R9 / R10 status and interrupt
    stat_lines = 5'b10110; epp_tmo = 1'b1;
    hread(16'h0001, 2'd0, 8'hB1, 1'b0, "R9 status no irq");
    @(negedge clk); ack_evt = 1'b1;
    @(negedge clk); ack_evt = 1'b0;
    chk({8'h0, irq}, 9'h0, "R10 ack ignored when disabled");
    hwrite(16'h0002, 2'd0, 8'h10);
    chk({5'h0, ctl_lines}, 9'h0, "R5 ien not on lines");
    @(negedge clk); ack_evt = 1'b1;
    @(negedge clk); ack_evt = 1'b0;
    chk({8'h0, irq}, 9'h1, "R10 ack sets irq");
    hread(16'h0001, 2'd0, 8'hB5, 1'b0, "R9 status with irq");
    chk({8'h0, irq}, 9'h0, "R9 irq cleared");
    // R10 set beats clear
    @(negedge clk); ack_evt = 1'b1;
    @(negedge clk); ack_evt = 1'b0;
    exp_q.push_back({1'b0, 8'hB5}); tag_q.push_back("R10 status during ack");
    hb_addr = 16'h0001; hb_size = 2'd0; hb_rd = 1'b1; ack_evt = 1'b1;
    @(negedge clk); hb_rd = 1'b0; ack_evt = 1'b0;
    chk({8'h0, irq}, 9'h1, "R10 set wins over clear");
    hread(16'h0001, 2'd0, 8'hB5, 1'b0, "R9 second status read");
    chk({8'h0, irq}, 9'h0, "R9 irq cleared again");

    // R3 wide accesses
    hwrite(16'h0000, 2'd2, 8'h77);
    chk({1'b0, pd_out}, 9'h05C, "R3 wide write ignored");
    hread(16'h0000, 2'd1, 8'hFF, 1'b1, "R3 wide read unused");

    // R4 reserved offsets
    hwrite(16'h0005, 2'd0, 8'h00);
    hwrite(16'h0007, 2'd0, 8'hFF);
    chk({1'b0, pd_out}, 9'h05C, "R4 reserved write pd_out");
    hread(16'h0002, 2'd0, 8'hD0, 1'b0, "R4 ctrl unchanged");
    hread(16'h0006, 2'd0, 8'hFF, 1'b0, "R4 reserved read");

    // R11 EPP writes
    @(negedge clk);
    hb_addr = 16'h0003; hb_size = 2'd0; hb_wdata = 8'h12; hb_wr = 1'b1;
    @(negedge clk); hb_wr = 1'b0;
    chk({epp_start, epp_addr, epp_write, 6'h0}, 9'h1C0, "R11 addr write pulse");
    chk({1'b0, epp_wdata}, 9'h012, "R11 addr write byte");
    @(negedge clk);
    chk({8'h0, epp_start}, 9'h0, "R11 pulse one cycle");
    hb_addr = 16'h0004; hb_wdata = 8'h34; hb_wr = 1'b1;
    @(negedge clk); hb_wr = 1'b0;
    chk({epp_start, epp_addr, epp_write, 6'h0}, 9'h140, "R11 data write pulse");
    chk({1'b0, epp_wdata}, 9'h034, "R11 data write byte");

    // R12 / R13 EPP read
    hread(16'h0004, 2'd0, 8'h9E, 1'b0, "R12 epp data read");
    chk({epp_start, epp_addr, epp_write, hb_busy, 5'h0}, 9'h120, "R12 read pulse and busy");
    hwrite(16'h0000, 2'd0, 8'h77);
    chk({1'b0, pd_out}, 9'h05C, "R13 write ignored while busy");
    epp_rdata = 8'h9E; epp_done = 1'b1;
    @(negedge clk); epp_done = 1'b0;
    chk({8'h0, hb_busy}, 9'h0, "R12 busy released");
    hread(16'h0002, 2'd0, 8'hD0, 1'b0, "R14 read after epp");

    repeat (3) @(negedge clk);
    chk(9'(exp_q.size()), 9'h0, "R14 all reads returned");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule